// File: doc/BRIEF.md
# Command-Response Buffer Register Block

This block is the memory-mapped front end of a security coprocessor. Host software talks to it over a simple 32-bit little-endian bus. Address bits [11:0] pick a register or a byte in the command buffer. Address bits [15:12] name the locality that issues the access. Through the registers the host:

- takes or gives up ownership of the interface;
- moves the coprocessor between idle and ready;
- places command bytes in a buffer that shares the same address window;
- launches a command.

A launch raises a one-cycle start pulse toward an external command engine. The engine reports the end of a command with a completion strobe and an error flag. Register layout used below (byte offsets):

| Offset | Register | Contents |
|---|---|---|
| 0x000 | locality state | bit0 established (1), bit1 assigned, bits [5:2] active locality, bit31 register-valid (1) |
| 0x008 | locality control | write-only: 1 = request access, 2 = relinquish |
| 0x00C | locality status | bit0 granted |
| 0x030 | interface ID low | see R2 |
| 0x034 | interface ID high | bits [15:0] vendor code |
| 0x040 | control request | write-only: 1 = ready, 2 = go idle |
| 0x044 | control status | bit0 fatal error, bit1 idle |
| 0x048 | cancel | write-only: 1 = cancel |
| 0x04C | start | bit0 start/busy; write 1 to launch |
| 0x058 | command size | |
| 0x05C / 0x060 | command address | low / high word |
| 0x064 | response size | |
| 0x068 / 0x06C | response address | low / high word |
| 0x080 up to 0x0FF | command buffer | |

Write sizes are 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. Write data sits in the low bytes of the write-data bus.

Top module: `crb_regif`

## Requirements
- R1: After reset:
  - locality state reads 0x8000_0001;
  - locality status reads 0;
  - control status reads 0x2 (idle set, fatal clear);
  - start reads 0;
  - both pulse outputs are low;
  - `owner_loc` holds the no-locality code, all ones.
- R2: Interface ID low reads a fixed word built from these fields:
  - [3:0] = 1 (active buffer type);
  - [7:4] = 1 (version);
  - [8] = 0 (locality 0 only);
  - [9] = 1 (fast idle bypass);
  - [12:11] = 3 (64-byte transfers);
  - [13] = 0 (no FIFO);
  - [14] = 1 (buffer interface supported);
  - [18:17] = 1 (buffer selector);
  - [31:28] = 0 (revision).

  Interface ID high reads the VENDOR_ID parameter in bits [15:0].
- R3: The command and response size registers read the buffer size. Both address pairs read BASE_ADDR + DBUF_OFF, split into a low word and a high word.
- R4: A write of 1 to locality control does three things:
  - it sets the assigned bit and the granted bit;
  - it records the writing locality (address bits [15:12]) as the active locality;
  - it drives `owner_loc` to that locality, with bit 4 clear.
- R5: A write of 2 to locality control clears the assigned bit and the granted bit, and `owner_loc` returns to all ones. The active-locality field keeps its last value.
- R6: Control request: a write of 1 clears the idle bit, and a write of 2 sets it. Any other value leaves control status unchanged.
- R7: A write of 1 to start is accepted only when all three hold:
  - the start bit is clear;
  - a locality is assigned;
  - the active locality equals the writing locality.

  Acceptance sets the start bit and raises `cmd_start` for exactly one cycle, starting the cycle after the write. Other values, or a write that fails any condition, have no effect.
- R8: A write of 1 to cancel raises `cmd_cancel` for one cycle, only while the start bit is set. Otherwise, or for any other value, there is no pulse.
- R9: `eng_done` clears the start bit. If `eng_err` is also high, the fatal bit is set, and it stays set until reset.
- R10: A write at or above offset 0x80 stores 1, 2 or 4 bytes, in little-endian order, at buffer index offset−0x80. This holds from any locality. A write whose last byte would lie past 0xFF is dropped whole, and so is any write at 0x100 or above.
- R11: A read returns its data in the cycle after the read strobe. The data is the aligned 32-bit word shifted right by 8 × address[1:0]. Write-only and unmapped offsets read 0. `bus_rdata` holds its value while no read is made.
- R12: Writes to these registers change nothing:
  - locality state and locality status;
  - interface ID;
  - control status;
  - the size and address registers.

  A bus write of 0 to start does not clear the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 16 | [15:12] locality, [11:0] byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, low bytes used first |
| bus_size | input | 2 | Write size code |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| cmd_start | output | 1 | One-cycle command launch pulse |
| cmd_cancel | output | 1 | One-cycle cancel pulse |
| eng_done | input | 1 | Completion strobe from the engine |
| eng_err | input | 1 | Error flag qualifying eng_done |
| owner_loc | output | 5 | Active locality, or all ones when none is assigned |

## Verification
Assertions check the following on every cycle:
- the launch pulse lasts one cycle and never follows a start write made while busy;
- a cancel pulse comes only after a busy cycle;
- completion clears the busy bit, and an error makes the fatal bit sticky;
- grant and relinquish take effect on the locality flags and the active locality;
- read data is held between reads.

Only the bench scenarios can show the rest:
- reset contents, the interface ID encoding and the address arithmetic;
- the full table of owning locality against writing locality for launches;
- byte-exact buffer contents under mixed write sizes;
- dropping of writes that run past the window;
- every sub-word read alignment.

// File: rtl/crb_pkg.sv
package crb_pkg;

  localparam int unsigned OFF_W = 12;
  typedef logic [OFF_W-1:0] off_t;

  // register byte offsets (all below the data buffer)
  localparam off_t A_LOC_STATE   = 12'h000;
  localparam off_t A_LOC_CTRL    = 12'h008;
  localparam off_t A_LOC_STS     = 12'h00C;
  localparam off_t A_IFID_LO     = 12'h030;
  localparam off_t A_IFID_HI     = 12'h034;
  localparam off_t A_CTRL_REQ    = 12'h040;
  localparam off_t A_CTRL_STS    = 12'h044;
  localparam off_t A_CTRL_CANCEL = 12'h048;
  localparam off_t A_CTRL_START  = 12'h04C;
  localparam off_t A_CMD_SIZE    = 12'h058;
  localparam off_t A_CMD_LO      = 12'h05C;
  localparam off_t A_CMD_HI      = 12'h060;
  localparam off_t A_RSP_SIZE    = 12'h064;
  localparam off_t A_RSP_LO      = 12'h068;
  localparam off_t A_RSP_HI      = 12'h06C;

  // command codes
  localparam logic [31:0] LOC_CODE_TAKE  = 32'd1;
  localparam logic [31:0] LOC_CODE_DROP  = 32'd2;
  localparam logic [31:0] REQ_CODE_READY = 32'd1;
  localparam logic [31:0] REQ_CODE_IDLE  = 32'd2;
  localparam logic [31:0] CODE_INVOKE    = 32'd1;

  // interface ID fields
  localparam logic [31:0] IFID_TYPE_ACTIVE = 32'd1;
  localparam logic [31:0] IFID_VERSION     = 32'd1;
  localparam logic [31:0] IFID_LOC0_ONLY   = 32'd0;
  localparam logic [31:0] IFID_IDLE_FAST   = 32'd1;
  localparam logic [31:0] IFID_XFER_64     = 32'd3;
  localparam logic [31:0] IFID_NO_FIFO     = 32'd0;
  localparam logic [31:0] IFID_BUF_OK      = 32'd1;
  localparam logic [31:0] IFID_SEL_BUF     = 32'd1;
  localparam logic [31:0] IFID_REV         = 32'd0;

  localparam logic [31:0] IFID_WORD =
      IFID_TYPE_ACTIVE
    | (IFID_VERSION   << 4)
    | (IFID_LOC0_ONLY << 8)
    | (IFID_IDLE_FAST << 9)
    | (IFID_XFER_64   << 11)
    | (IFID_NO_FIFO   << 13)
    | (IFID_BUF_OK    << 14)
    | (IFID_SEL_BUF   << 17)
    | (IFID_REV       << 28);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } wsize_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (wsize_e'(code))
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/crb_loc_ctrl.sv
module crb_loc_ctrl #(
  parameter int unsigned LOC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_wr,
  input  logic             drop_wr,
  input  logic [LOC_W-1:0] wr_loc,
  output logic             assigned,
  output logic             granted,
  output logic [LOC_W-1:0] active_loc
);

  logic             assigned_q, assigned_d;
  logic             granted_q, granted_d;
  logic [LOC_W-1:0] active_q, active_d;
  logic             upd_en;

  assign upd_en = take_wr | drop_wr;

  always_comb begin
    assigned_d = assigned_q;
    granted_d  = granted_q;
    active_d   = active_q;
    if (take_wr) begin
      assigned_d = 1'b1;
      granted_d  = 1'b1;
      active_d   = wr_loc;
    end else if (drop_wr) begin
      assigned_d = 1'b0;
      granted_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      assigned_q <= 1'b0;
      granted_q  <= 1'b0;
      active_q   <= '0;
    end else if (upd_en) begin
      assigned_q <= assigned_d;
      granted_q  <= granted_d;
      active_q   <= active_d;
    end
  end

  assign assigned   = assigned_q;
  assign granted    = granted_q;
  assign active_loc = active_q;

  // R4: a grant records the requester and marks the interface owned
  p_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_wr |=> (assigned && granted && active_loc == $past(wr_loc)));

  // R5: relinquish releases ownership
  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_wr && !take_wr) |=> (!assigned && !granted));

endmodule

// File: rtl/crb_cmd_ctrl.sv
module crb_cmd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_ready,
  input  logic req_idle,
  input  logic start_wr,
  input  logic cancel_wr,
  input  logic owner_match,
  input  logic eng_done,
  input  logic eng_err,
  output logic start_bit,
  output logic idle_bit,
  output logic fatal_bit,
  output logic cmd_start,
  output logic cmd_cancel
);

  logic start_q, start_d;
  logic idle_q, idle_d;
  logic fatal_q, fatal_d;
  logic go_q, go_d;
  logic cxl_q, cxl_d;
  logic start_acc;
  logic st_en;

  assign start_acc = start_wr & ~start_q & owner_match;
  assign st_en     = start_acc | eng_done | req_ready | req_idle;

  always_comb begin
    start_d = start_q;
    if (start_acc)     start_d = 1'b1;
    else if (eng_done) start_d = 1'b0;

    idle_d = idle_q;
    if (req_ready)     idle_d = 1'b0;
    else if (req_idle) idle_d = 1'b1;

    fatal_d = fatal_q | (eng_done & eng_err);
    go_d    = start_acc;
    cxl_d   = cancel_wr & start_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      idle_q  <= 1'b1;
      fatal_q <= 1'b0;
    end else if (st_en) begin
      start_q <= start_d;
      idle_q  <= idle_d;
      fatal_q <= fatal_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q  <= 1'b0;
      cxl_q <= 1'b0;
    end else begin
      go_q  <= go_d;
      cxl_q <= cxl_d;
    end
  end

  assign start_bit  = start_q;
  assign idle_bit   = idle_q;
  assign fatal_bit  = fatal_q;
  assign cmd_start  = go_q;
  assign cmd_cancel = cxl_q;

  // R7: launch pulse is one cycle wide
  p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);

  // R7: no launch from a start write while busy
  p_busy_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && start_bit) |=> !cmd_start);

  // R8: cancel pulse only after a busy cycle
  p_cancel_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cancel |-> $past(start_bit));

  // R9: completion ends a command
  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && start_bit) |=> !start_bit);

  // R9: an error raises fatal
  p_err_fatal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && eng_err) |=> fatal_bit);

  // R9: fatal is sticky
  p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_bit |=> fatal_bit);

  // R6: ready request drops idle
  p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !idle_bit);

endmodule

// File: rtl/crb_dbuf.sv
module crb_dbuf #(
  parameter  int unsigned BYTES = 128,
  localparam int unsigned AW    = $clog2(BYTES),
  localparam int unsigned WW    = AW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [2:0]    nbytes,
  input  logic [WW-1:0] ridx,
  output logic [31:0]   rword
);

  logic [7:0] mem_q [BYTES];
  logic [7:0] mem_d [BYTES];
  logic [AW:0] widx;

  always_comb begin
    mem_d = mem_q;
    widx  = '0;
    for (int k = 0; k < 4; k++) begin
      widx = {1'b0, waddr} + (AW+1)'(k);
      if (we && (3'(k) < nbytes) && (widx < (AW+1)'(BYTES)))
        mem_d[widx[AW-1:0]] = wdata[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q <= mem_d;
    end
  end

  assign rword = {mem_q[{ridx, 2'd3}], mem_q[{ridx, 2'd2}],
                  mem_q[{ridx, 2'd1}], mem_q[{ridx, 2'd0}]};

endmodule

// File: rtl/crb_regif.sv
module crb_regif
  import crb_pkg::*;
#(
  parameter  int unsigned LOC_W      = 4,
  parameter  int unsigned DBUF_OFF   = 128,
  parameter  int unsigned DBUF_BYTES = 128,
  parameter  logic [63:0] BASE_ADDR  = 64'h0000_0001_FED4_0000,
  parameter  logic [15:0] VENDOR_ID  = 16'hA5C3,
  localparam int unsigned AW_BUS     = OFF_W + LOC_W,
  localparam int unsigned WIN_BYTES  = DBUF_OFF + DBUF_BYTES,
  localparam int unsigned DB_AW      = $clog2(DBUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW_BUS-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic [1:0]        bus_size,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              cmd_start,
  output logic              cmd_cancel,
  input  logic              eng_done,
  input  logic              eng_err,
  output logic [LOC_W:0]    owner_loc
);

  localparam logic [LOC_W:0] NO_LOC   = '1;
  localparam logic [63:0]    BUF_ADDR = BASE_ADDR + 64'(DBUF_OFF);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_int_n = rst_sync_q;

  // address split
  off_t             off;
  logic [LOC_W-1:0] wloc;
  logic [2:0]       nb;
  logic [OFF_W:0]   wend;
  logic             in_dbuf, in_win, fits;
  logic             reg_wr, dbuf_we;
  off_t             rel;

  assign off     = bus_addr[OFF_W-1:0];
  assign wloc    = bus_addr[OFF_W +: LOC_W];
  assign nb      = size_bytes(bus_size);
  assign wend    = {1'b0, off} + {{(OFF_W-2){1'b0}}, nb};
  assign in_dbuf = (off >= OFF_W'(DBUF_OFF));
  assign in_win  = in_dbuf && (off < OFF_W'(WIN_BYTES));
  assign fits    = (wend <= (OFF_W+1)'(WIN_BYTES));
  assign reg_wr  = bus_wr && !in_dbuf;
  assign dbuf_we = bus_wr && in_dbuf && fits;
  assign rel     = off - OFF_W'(DBUF_OFF);

  // write decode
  logic take_wr, drop_wr, req_ready, req_idle, start_wr, cancel_wr;
  assign take_wr   = reg_wr && (off == A_LOC_CTRL)    && (bus_wdata == LOC_CODE_TAKE);
  assign drop_wr   = reg_wr && (off == A_LOC_CTRL)    && (bus_wdata == LOC_CODE_DROP);
  assign req_ready = reg_wr && (off == A_CTRL_REQ)    && (bus_wdata == REQ_CODE_READY);
  assign req_idle  = reg_wr && (off == A_CTRL_REQ)    && (bus_wdata == REQ_CODE_IDLE);
  assign start_wr  = reg_wr && (off == A_CTRL_START)  && (bus_wdata == CODE_INVOKE);
  assign cancel_wr = reg_wr && (off == A_CTRL_CANCEL) && (bus_wdata == CODE_INVOKE);

  // locality tracking
  logic             loc_assigned, loc_granted;
  logic [LOC_W-1:0] loc_active;

  crb_loc_ctrl #(.LOC_W(LOC_W)) u_loc (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .take_wr    (take_wr),
    .drop_wr    (drop_wr),
    .wr_loc     (wloc),
    .assigned   (loc_assigned),
    .granted    (loc_granted),
    .active_loc (loc_active)
  );

  logic owner_match;
  assign owner_match = loc_assigned && (loc_active == wloc);
  assign owner_loc   = loc_assigned ? {1'b0, loc_active} : NO_LOC;

  // command control
  logic start_bit, idle_bit, fatal_bit;

  crb_cmd_ctrl u_cmd (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_ready   (req_ready),
    .req_idle    (req_idle),
    .start_wr    (start_wr),
    .cancel_wr   (cancel_wr),
    .owner_match (owner_match),
    .eng_done    (eng_done),
    .eng_err     (eng_err),
    .start_bit   (start_bit),
    .idle_bit    (idle_bit),
    .fatal_bit   (fatal_bit),
    .cmd_start   (cmd_start),
    .cmd_cancel  (cmd_cancel)
  );

  // command buffer
  logic [31:0] db_rword;

  crb_dbuf #(.BYTES(DBUF_BYTES)) u_dbuf (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we     (dbuf_we),
    .waddr  (rel[DB_AW-1:0]),
    .wdata  (bus_wdata),
    .nbytes (nb),
    .ridx   (rel[DB_AW-1:2]),
    .rword  (db_rword)
  );

  // read path
  off_t        word_off;
  logic [31:0] loc_state_w, rd_word, rdata_d, rdata_q;

  assign word_off = {off[OFF_W-1:2], 2'b00};

  always_comb begin
    loc_state_w              = '0;
    loc_state_w[0]           = 1'b1;
    loc_state_w[1]           = loc_assigned;
    loc_state_w[2 +: LOC_W]  = loc_active;
    loc_state_w[31]          = 1'b1;
  end

  always_comb begin
    rd_word = '0;
    if (in_win) begin
      rd_word = db_rword;
    end else if (!in_dbuf) begin
      case (word_off)
        A_LOC_STATE:  rd_word = loc_state_w;
        A_LOC_STS:    rd_word = {31'd0, loc_granted};
        A_IFID_LO:    rd_word = IFID_WORD;
        A_IFID_HI:    rd_word = {16'd0, VENDOR_ID};
        A_CTRL_STS:   rd_word = {30'd0, idle_bit, fatal_bit};
        A_CTRL_START: rd_word = {31'd0, start_bit};
        A_CMD_SIZE:   rd_word = 32'(DBUF_BYTES);
        A_CMD_LO:     rd_word = BUF_ADDR[31:0];
        A_CMD_HI:     rd_word = BUF_ADDR[63:32];
        A_RSP_SIZE:   rd_word = 32'(DBUF_BYTES);
        A_RSP_LO:     rd_word = BUF_ADDR[31:0];
        A_RSP_HI:     rd_word = BUF_ADDR[63:32];
        default:      rd_word = '0;
      endcase
    end
  end

  assign rdata_d = rd_word >> {off[1:0], 3'b000};

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R11: read data holds between reads
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_rd |=> $stable(bus_rdata));

  // R7: a launch pulse follows only an owning-locality start write
  p_launch_owner_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_start |-> $past(start_wr && owner_match));

endmodule

// File: tb/tb_crb_regif.sv
module tb_crb_regif;
  import crb_pkg::*;

  localparam logic [63:0] BASE = 64'h0000_0001_FED4_0000;
  localparam logic [15:0] VID  = 16'hA5C3;
  localparam int          DOFF = 128;
  localparam int          DBYT = 128;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic        cmd_start, cmd_cancel, eng_done, eng_err;
  logic [4:0]  owner_loc;

  int vecs  = 0;
  int fails = 0;
  logic [7:0] m [DBYT];

  always #10 clk = ~clk;

  crb_regif dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_size(bus_size), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .cmd_start(cmd_start), .cmd_cancel(cmd_cancel),
    .eng_done(eng_done), .eng_err(eng_err), .owner_loc(owner_loc)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rchk(input string req, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic done(input logic e);
    @(negedge clk);
    eng_done = 1'b1; eng_err = e;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0;
  endtask

  function automatic logic [31:0] mword(input int o);
    int w;
    logic [31:0] x;
    w = o & ~3;
    x = {m[w+3], m[w+2], m[w+1], m[w]};
    return x >> (8 * (o & 3));
  endfunction

  function automatic logic [15:0] la(input int loc, input int off);
    return 16'((loc << 12) | off);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got timeout exp finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    logic [31:0] ifid, d;
    logic [63:0] ba;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; bus_size = '0; eng_done = 1'b0; eng_err = 1'b0;
    for (int i = 0; i < DBYT; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rchk("R1 loc_state", 16'h000, 32'h8000_0001);
    rchk("R1 loc_sts",   16'h00C, 32'h0);
    rchk("R1 ctrl_sts",  16'h044, 32'h2);
    rchk("R1 start",     16'h04C, 32'h0);
    chk("R1 owner", 32'(owner_loc), 32'h1F);
    chk("R1 pulses", {30'd0, cmd_start, cmd_cancel}, 32'h0);

    // R2 interface ID
    ifid = 32'd1 | (32'd1 << 4) | (32'd1 << 9) | (32'd3 << 11) | (32'd1 << 14) | (32'd1 << 17);
    rchk("R2 ifid_lo", 16'h030, ifid);
    rchk("R2 ifid_hi", 16'h034, {16'd0, VID});

    // R3 sizes and addresses
    ba = BASE + 64'(DOFF);
    rchk("R3 cmd_size", 16'h058, 32'(DBYT));
    rchk("R3 cmd_lo",   16'h05C, ba[31:0]);
    rchk("R3 cmd_hi",   16'h060, ba[63:32]);
    rchk("R3 rsp_size", 16'h064, 32'(DBYT));
    rchk("R3 rsp_lo",   16'h068, ba[31:0]);
    rchk("R3 rsp_hi",   16'h06C, ba[63:32]);

    // R11 sub-word reads and zero reads
    for (int o = 0; o < 4; o++) begin
      rchk("R11 ifid shift", 16'(16'h030 + o), ifid >> (8 * o));
      rchk("R11 addr shift", 16'(16'h05C + o), ba[31:0] >> (8 * o));
    end
    rchk("R11 write-only reads 0", 16'h008, 32'h0);
    rchk("R11 unmapped reads 0",   16'h074, 32'h0);

    // R12 read-only registers
    wr(16'h030, 2'd2, 32'hFFFF_FFFF);
    wr(16'h044, 2'd2, 32'hFFFF_FFFF);
    wr(16'h00C, 2'd2, 32'hFFFF_FFFF);
    wr(16'h000, 2'd2, 32'hFFFF_FFFF);
    wr(16'h05C, 2'd2, 32'h1234_5678);
    wr(16'h058, 2'd2, 32'h0);
    rchk("R12 ifid", 16'h030, ifid);
    rchk("R12 ctrl_sts", 16'h044, 32'h2);
    rchk("R12 loc_sts", 16'h00C, 32'h0);
    rchk("R12 loc_state", 16'h000, 32'h8000_0001);
    rchk("R12 cmd_lo", 16'h05C, ba[31:0]);
    rchk("R12 cmd_size", 16'h058, 32'(DBYT));

    // R6 control request
    wr(16'h040, 2'd2, 32'd1);
    rchk("R6 ready clears idle", 16'h044, 32'h0);
    wr(16'h040, 2'd2, 32'd7);
    rchk("R6 other code ignored", 16'h044, 32'h0);
    wr(16'h040, 2'd2, 32'd2);
    rchk("R6 go idle sets idle", 16'h044, 32'h2);
    wr(16'h040, 2'd2, 32'd0);
    rchk("R6 zero ignored", 16'h044, 32'h2);

    // R7 start without owner
    wr(16'h04C, 2'd2, 32'd1);
    chk("R7 no owner no pulse", 32'(cmd_start), 32'h0);
    rchk("R7 no owner start clear", 16'h04C, 32'h0);

    // R4 grant locality 2
    wr(la(2, 8), 2'd2, 32'd1);
    chk("R4 owner", 32'(owner_loc), 32'd2);
    rchk("R4 loc_state", 16'h000, 32'h8000_0003 | (32'd2 << 2));
    rchk("R4 loc_sts", 16'h00C, 32'h1);

    wr(la(1, 16'h04C), 2'd2, 32'd1);
    chk("R7 wrong locality", 32'(cmd_start), 32'h0);
    wr(la(2, 16'h04C), 2'd2, 32'd3);
    chk("R7 wrong value", 32'(cmd_start), 32'h0);
    wr(la(2, 16'h048), 2'd2, 32'd1);
    chk("R8 cancel idle no pulse", 32'(cmd_cancel), 32'h0);

    wr(la(2, 16'h04C), 2'd2, 32'd1);
    chk("R7 accepted pulse", 32'(cmd_start), 32'h1);
    @(negedge clk);
    chk("R7 pulse one cycle", 32'(cmd_start), 32'h0);
    rchk("R7 start bit set", 16'h04C, 32'h1);
    wr(la(2, 16'h04C), 2'd2, 32'd1);
    chk("R7 busy rejected", 32'(cmd_start), 32'h0);
    wr(la(2, 16'h04C), 2'd2, 32'd0);
    rchk("R12 start not cleared by write", 16'h04C, 32'h1);

    wr(la(2, 16'h048), 2'd2, 32'd2);
    chk("R8 cancel bad value", 32'(cmd_cancel), 32'h0);
    wr(la(2, 16'h048), 2'd2, 32'd1);
    chk("R8 cancel pulse", 32'(cmd_cancel), 32'h1);
    @(negedge clk);
    chk("R8 cancel one cycle", 32'(cmd_cancel), 32'h0);

    done(1'b0);
    rchk("R9 done clears start", 16'h04C, 32'h0);
    rchk("R9 no error no fatal", 16'h044, 32'h2);
    wr(la(2, 16'h04C), 2'd2, 32'd1);
    chk("R7 relaunch", 32'(cmd_start), 32'h1);
    done(1'b1);
    rchk("R9 done clears start err", 16'h04C, 32'h0);
    rchk("R9 error sets fatal", 16'h044, 32'h3);
    done(1'b0);
    rchk("R9 fatal sticky", 16'h044, 32'h3);

    // R5 relinquish
    wr(la(2, 8), 2'd2, 32'd2);
    chk("R5 owner none", 32'(owner_loc), 32'h1F);
    rchk("R5 loc_sts", 16'h00C, 32'h0);
    rchk("R5 loc_state", 16'h000, 32'h8000_0001 | (32'd2 << 2));
    wr(la(2, 16'h04C), 2'd2, 32'd1);
    chk("R5 start after drop rejected", 32'(cmd_start), 32'h0);

    // R4 R7 sweep owner x writer
    for (int l = 0; l < 16; l++) begin
      wr(la(l, 8), 2'd2, 32'd1);
      chk("R4 sweep owner", 32'(owner_loc), 32'(l));
      for (int w = 0; w < 16; w++) begin
        wr(la(w, 16'h04C), 2'd2, 32'd1);
        chk("R7 sweep pulse", 32'(cmd_start), (w == l) ? 32'h1 : 32'h0);
        if (w == l) done(1'b0);
      end
    end
    wr(la(15, 8), 2'd2, 32'd2);

    // R10 buffer: bytes from many localities
    for (int i = 0; i < DBYT; i++) begin
      m[i] = 8'((i * 37 + 5) & 255);
      wr(la(i % 16, DOFF + i), 2'd0, 32'(m[i]) | 32'hFFFF_FF00);
    end
    for (int i = 1; i < 126; i += 7) begin
      d = 32'(i * 32'h0101 + 32'h1234);
      m[i] = d[7:0]; m[i+1] = d[15:8];
      wr(16'(DOFF + i), 2'd1, d | 32'hAB00_0000);
    end
    for (int i = 2; i < 121; i += 9) begin
      d = (32'(i) * 32'h0101_0101) ^ 32'hA5A5_5A5A;
      m[i] = d[7:0]; m[i+1] = d[15:8]; m[i+2] = d[23:16]; m[i+3] = d[31:24];
      wr(16'(DOFF + i), 2'd2, d);
    end
    wr(16'(DOFF + 126), 2'd2, 32'hDEAD_BEEF);
    wr(16'(DOFF + 127), 2'd1, 32'h0000_C0DE);
    wr(16'(DOFF + 124), 2'd3, 32'h4433_2211);
    m[124] = 8'h11; m[125] = 8'h22; m[126] = 8'h33; m[127] = 8'h44;
    wr(16'(DOFF + 127), 2'd2, 32'h9999_9999);
    wr(16'(DOFF + 128), 2'd2, 32'h7777_7777);
    rchk("R10 past window reads 0", 16'(DOFF + 128), 32'h0);
    for (int o = 0; o < DBYT; o++)
      rchk("R10 R11 buffer read", 16'(DOFF + o), mword(o));

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule